// File: doc/BRIEF.md
# In-Place FFT Data Address Sequencer

This block produces the data memory address stream for a 256-point radix-2 decimation-in-frequency FFT that computes in place. Each butterfly takes two cycles, so each 256-cycle stage presents every memory word once. Each butterfly's two operands appear on consecutive cycles, and their separation halves from one stage to the next. The address is held in an 8-bit register that adds a per-stage step with end-around carry: the carry out of the top bit is added back in at the bottom. The step comes from a twisted-ring (Johnson) stage counter. Its lowest set bit is the step, so the step is 128 in the first stage and 1 in the last.

The memory subsystem uses two copies of the block. The read-side copy has no lag. The write-side copy is built with a lag of 9 enabled cycles, which equals the butterfly pipeline depth, so results return to the same locations they were read from. While no transform is running, the address drive-enable is low so that outside logic can use the address bus to load samples and unload results.

Top module: `fft_addr_gen`

## Requirements
- R1: In stage s (0 to 7), the n-th enabled cycle of the stage (n from 0 to 255) carries address 255 when n is 255, and (n * 2^(7-s)) mod 255 otherwise.
- R2: Within every stage, each of the 256 address values appears exactly once.
- R3: A run lasts 8 stages of 256 enabled cycles, 2048 in all. After that, addr_oe drops to 0 until the next start.
- R4: stage_done is 1 exactly in the last cycle of each stage, and the address in that cycle is 255.
- R5: done is 1 only in the final cycle of the eighth stage, and stage_done is also 1 in that cycle.
- R6: While no run is active, addr_oe is 0 and addr is 0.
- R7: start is sampled on enabled clock edges. The first address (0, stage 0) appears LAG_CYC enabled edges after the edge that samples start. A copy with LAG_CYC = 9 repeats the address stream of a zero-lag copy exactly 9 cycles later, including its addr_oe and done timing.
- R8: While en is 0, nothing advances: addr, addr_oe, the stage position and the start lag all hold.
- R9: A start sampled during a run restarts the run at stage 0 with address 0.
- R10: While rst_n is 0, and directly after reset, addr_oe, stage_done and done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin (or restart) a transform; sampled when en is 1 |
| en | input | 1 | Advance enable; 0 freezes the block |
| addr | output | 8 | Data memory address; 0 while idle |
| addr_oe | output | 1 | 1 while the block drives the address bus |
| stage_done | output | 1 | Marks the last cycle of a stage |
| done | output | 1 | Marks the last cycle of the whole transform |

## Verification
On every cycle, the assertions check the following: each stage opens at address 0 and closes at 255; done coincides with stage_done and is followed by release of the bus; the address changes on every enabled step inside a stage; and a disabled cycle changes nothing. The exact per-stage value sequence, the coverage of all 256 values in each stage, the 2048-cycle run length, the 9-cycle trailing copy, pause timing inside the start lag, and restart in the middle of a run can only be shown by the bench's scenarios, which compare against a formula of their own.

// File: rtl/fft_ag_pkg.sv
package fft_ag_pkg;
  parameter int unsigned AG_ADDR_W = 8;

  typedef logic [AG_ADDR_W-1:0] ag_word_t;

  // ones'-complement style add: carry out of the top bit re-enters at bit 0
  function automatic ag_word_t eac_add(input ag_word_t a, input ag_word_t b);
    logic [AG_ADDR_W:0] wide;
    wide = {1'b0, a} + {1'b0, b};
    return wide[AG_ADDR_W-1:0] + ag_word_t'(wide[AG_ADDR_W]);
  endfunction

  // lowest set bit of a twisted-ring value filled from the top
  function automatic ag_word_t ring_step(input ag_word_t ring);
    return ring & ~(ring << 1);
  endfunction

  function automatic ag_word_t ring_first();
    ag_word_t r;
    r = '0;
    r[AG_ADDR_W-1] = 1'b1;
    return r;
  endfunction
endpackage

// File: rtl/ag_start_lag.sv
module ag_start_lag #(
  parameter int unsigned LAG = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic go_in,
  output logic go_out
);
  generate
    if (LAG == 0) begin : g_direct
      assign go_out = go_in;
    end else begin : g_pipe
      logic [LAG-1:0] line_q;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          line_q <= '0;
        end else if (en) begin
          if (LAG == 1) line_q <= go_in;
          else          line_q <= {line_q[LAG-2:0], go_in} ;
        end
      end
      assign go_out = line_q[LAG-1];
    end
  endgenerate
endmodule

// File: rtl/ag_stage_seq.sv
module ag_stage_seq
  import fft_ag_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     kick,
  output logic     active,
  output ag_word_t ring,
  output logic     stage_first,
  output logic     stage_last,
  output logic     run_last
);
  ag_word_t pos_q;
  ag_word_t ring_q;
  logic     active_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pos_q    <= '0;
      ring_q   <= '0;
    end else if (en) begin
      if (kick) begin
        active_q <= 1'b1;
        pos_q    <= '0;
        ring_q   <= ring_first();
      end else if (active_q) begin
        pos_q <= pos_q + ag_word_t'(1);
        if (&pos_q) begin
          if (&ring_q) active_q <= 1'b0;
          else         ring_q   <= {1'b1, ring_q[AG_ADDR_W-1:1]};
        end
      end
    end
  end

  assign active      = active_q;
  assign ring        = ring_q;
  assign stage_first = active_q && (pos_q == '0);
  assign stage_last  = active_q && (&pos_q);
  assign run_last    = stage_last && (&ring_q);
endmodule

// File: rtl/ag_accum.sv
module ag_accum
  import fft_ag_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  logic     kick,
  input  logic     active,
  input  logic     stage_last,
  input  ag_word_t step,
  output ag_word_t acc
);
  ag_word_t acc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (en) begin
      if (kick || stage_last) acc_q <= '0;
      else if (active)        acc_q <= eac_add(acc_q, step);
    end
  end

  assign acc = acc_q;
endmodule

// File: rtl/fft_addr_gen.sv
module fft_addr_gen
  import fft_ag_pkg::*;
#(
  parameter int unsigned LAG_CYC = 0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic                 en,
  output logic [AG_ADDR_W-1:0] addr,
  output logic                 addr_oe,
  output logic                 stage_done,
  output logic                 done
);
  logic     kick;
  logic     active;
  ag_word_t ring;
  ag_word_t acc;
  logic     stage_first;
  logic     stage_last;
  logic     run_last;

  ag_start_lag #(.LAG(LAG_CYC)) u_lag (
    .clk(clk), .rst_n(rst_n), .en(en), .go_in(start), .go_out(kick)
  );

  ag_stage_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .kick(kick),
    .active(active), .ring(ring), .stage_first(stage_first),
    .stage_last(stage_last), .run_last(run_last)
  );

  ag_accum u_acc (
    .clk(clk), .rst_n(rst_n), .en(en), .kick(kick), .active(active),
    .stage_last(stage_last), .step(ring_step(ring)), .acc(acc)
  );

  assign addr       = active ? acc : '0;
  assign addr_oe    = active;
  assign stage_done = stage_last;
  assign done       = run_last;
endmodule

// File: rtl/fft_addr_gen_chk.sv
module fft_addr_gen_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en,
  input logic         kick,
  input logic [W-1:0] addr,
  input logic         addr_oe,
  input logic         stage_done,
  input logic         done,
  input logic         stage_first
);
  a_r1_stage_opens_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    stage_first |-> addr == '0);

  a_r1_steps_move: assert property (@(posedge clk) disable iff (!rst_n)
    (en && addr_oe && !stage_done && !kick) |=> (addr_oe && addr != $past(addr)));

  a_r4_stage_closes_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    stage_done |-> addr == {W{1'b1}});

  a_r5_done_within_stage_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> stage_done);

  a_r5_done_releases_bus: assert property (@(posedge clk) disable iff (!rst_n)
    (done && en && !kick) |=> !addr_oe);

  a_r8_frozen_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(addr) && $stable(addr_oe) && $stable(stage_done)));
endmodule

bind fft_addr_gen fft_addr_gen_chk #(.W(fft_ag_pkg::AG_ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .kick(kick), .addr(addr),
  .addr_oe(addr_oe), .stage_done(stage_done), .done(done),
  .stage_first(stage_first)
);

// File: tb/fft_addr_gen_test.sv
module fft_addr_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic en = 1'b1;
  logic [7:0] addr, addr_l;
  logic oe, oe_l, sd, sd_l, dn, dn_l;

  int total = 0;
  int bad = 0;
  int rec [0:2047];

  always #2.5 clk = ~clk;

  fft_addr_gen #(.LAG_CYC(0)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .en(en),
    .addr(addr), .addr_oe(oe), .stage_done(sd), .done(dn)
  );

  fft_addr_gen #(.LAG_CYC(9)) uut_lag (
    .clk(clk), .rst_n(rst_n), .start(start), .en(en),
    .addr(addr_l), .addr_oe(oe_l), .stage_done(sd_l), .done(dn_l)
  );

  // stage, index within stage, expected address
  localparam int PROBE [0:9][0:2] = '{
    '{0, 1, 128}, '{0, 2, 1}, '{1, 3, 192}, '{1, 4, 1}, '{2, 5, 160},
    '{3, 17, 17}, '{4, 32, 1}, '{5, 64, 1}, '{6, 200, 145}, '{7, 100, 100}
  };

  function automatic int want(input int s, input int n);
    if (n == 255) return 255;
    return (n * (1 << (7 - s))) % 255;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog R3 actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int t;
    int ticks;
    #1;
    tick(); tick();
    // R10 / R6: reset and idle state
    chk(!oe && !sd && !dn, "R10 reset outputs", {oe, sd, dn}, 0);
    chk(!oe_l && !dn_l, "R10 lag reset outputs", {oe_l, dn_l}, 0);
    rst_n = 1'b1;
    tick();
    chk(addr == 0 && !oe, "R6 idle bus", addr, 0);

    // full run, both copies
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int k = 0; k <= 2057; k++) begin
      if (k < 2048) begin
        rec[k] = addr;
        chk(oe == 1'b1, "R3 bus driven during run", oe, 1);
        chk(addr == want(k / 256, k % 256), "R1 address sequence", addr, want(k / 256, k % 256));
        chk(sd == ((k % 256) == 255), "R4 stage_done timing", sd, (k % 256) == 255);
        chk(dn == (k == 2047), "R5 done timing", dn, k == 2047);
      end else begin
        chk(!oe && addr == 0, "R3 released after 2048", addr + 256 * oe, 0);
      end
      if (k < 9 || k > 2056) begin
        chk(!oe_l, "R7 lag copy idle", oe_l, 0);
      end else begin
        chk(oe_l && addr_l == want((k - 9) / 256, (k - 9) % 256),
            "R7 lag copy trails by 9", addr_l, want((k - 9) / 256, (k - 9) % 256));
        chk(dn_l == (k == 2056), "R7 lag done timing", dn_l, k == 2056);
      end
      tick();
    end

    // R2: every value once per stage
    for (int s = 0; s < 8; s++) begin
      bit [255:0] seen;
      int distinct;
      seen = '0;
      distinct = 0;
      for (int n = 0; n < 256; n++) begin
        if (!seen[rec[s * 256 + n]]) distinct++;
        seen[rec[s * 256 + n]] = 1'b1;
      end
      chk(distinct == 256, "R2 distinct addresses per stage", distinct, 256);
    end

    // probe table of hand-computed points (R1)
    for (int i = 0; i < 10; i++) begin
      chk(rec[PROBE[i][0] * 256 + PROBE[i][1]] == PROBE[i][2], "R1 probe point",
          rec[PROBE[i][0] * 256 + PROBE[i][1]], PROBE[i][2]);
    end

    // R8: pause inside the run and inside the start lag
    start = 1'b1;
    tick();
    start = 1'b0;
    for (int k = 0; k < 5; k++) tick();
    chk(addr == want(0, 5), "R8 before pause", addr, want(0, 5));
    en = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk(addr == want(0, 5) && oe, "R8 address held", addr, want(0, 5));
      chk(!oe_l, "R8 lag paused", oe_l, 0);
    end
    en = 1'b1;
    tick();
    chk(addr == want(0, 6), "R8 resume", addr, want(0, 6));
    tick(); tick();
    chk(!oe_l, "R8 lag not yet started", oe_l, 0);
    tick();
    chk(oe_l && addr_l == 0, "R8 lag starts after 9 enabled edges", addr_l + 256 * oe_l, 256);

    // R9: restart in the middle of a run
    start = 1'b1;
    tick();
    start = 1'b0;
    chk(oe && addr == 0 && !sd, "R9 restart at zero", addr, 0);
    tick();
    chk(addr == 128, "R9 restart sequence", addr, 128);
    ticks = 1;
    t = 0;
    while (oe && t < 3000) begin
      tick();
      ticks++;
      t++;
    end
    chk(ticks == 2048, "R3 run length after restart", ticks, 2048);

    // R10: reset during a run
    start = 1'b1;
    tick();
    start = 1'b0;
    tick();
    rst_n = 1'b0;
    tick();
    chk(!oe && !sd && !dn && addr == 0, "R10 reset mid-run", addr + 256 * oe, 0);
    rst_n = 1'b1;
    tick();
    chk(!oe && addr == 0, "R6 idle after reset", addr, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule